// File: doc/BRIEF.md
# Bit-Parallel Marker Run Matcher

This block scans text in fixed-width blocks, one bit per character position. For each block it receives three character-class masks: the letter `a`, the decimal digits, and the terminator set `z`/`9`. It returns three marker masks for the pattern "a, then any number of digits, then z or 9".

A marker bit at position k means that character k is the next one still to be matched. The first marker mask is the `a` class moved forward by one position. The second marker mask extends every marker through any run of digits in a single integer addition. It marks all reachable positions, not only the end of the longest run. The third marker mask keeps the second mask's bits that sit on a terminator and moves them forward by one position.

Between consecutive blocks of a stream, the block keeps the addition carry and the two shift carries. The per-block results are therefore the same as for one unbroken stream. A start-of-stream flag on the first block makes that block use zero carries. Blocks enter and results leave through a valid/ready handshake, one block per accepted transfer.

Top module: `mstar_engine`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Bit k of `afterA` is 1 exactly when stream character k-1 is `a` (the class shifted toward higher positions by one).
- R3: `afterRun` equals `(((afterA & clsDigit) + clsDigit) ^ clsDigit) | afterA`. The sum runs toward higher bit positions, and every bit set in `afterA` is also set in `afterRun`.
- R4: Every reachable end is marked. For the block text `a12949z` followed by filler, `afterEnd` is 16'h00D0 (bits 4, 6 and 7).
- R5: Bit k of `afterEnd` is 1 exactly when bit k-1 of the stream's `afterRun` is 1 and character k-1 is `z` or `9`.
- R6: The addition carry leaving bit W-1 of one block enters bit 0 of the next block of the same stream. This includes carries that ripple through sum fields of all ones when the adder is split into `FIELD_W` fields.
- R7: The top bits of the `a` mask and of the terminated run mask feed bit 0 of the next block's `afterA` and `afterEnd`.
- R8: A block accepted with `startStream` = 1 uses zero for all three carries, so bit 0 of `afterA` and `afterEnd` is 0. `startStream` has no effect when no block is accepted.
- R9: A block is taken on a clock edge where `inValid` and `inReady` are both 1. Its results appear with `outValid` = 1 after that edge. `inReady` equals `!outValid || outReady`. While `outValid` is 1 and `outReady` is 0, the outputs hold. Class inputs presented with `inValid` = 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Block offered |
| inReady | output | 1 | Block can be taken this cycle |
| startStream | input | 1 | Offered block is the first of a new stream |
| clsA | input | BLOCK_W | Class mask for `a` |
| clsDigit | input | BLOCK_W | Class mask for digits |
| clsEnd | input | BLOCK_W | Class mask for `z` and `9` |
| outValid | output | 1 | Result masks valid |
| outReady | input | 1 | Consumer takes the result |
| afterA | output | BLOCK_W | Markers after the `a` step |
| afterRun | output | BLOCK_W | Markers after the digit run |
| afterEnd | output | BLOCK_W | Markers after the terminator |

## Verification
A block boundary can coincide with a new stream. The stream-start clear and the carries left by the previous stream's last block then meet on the same accepted block. The bench provokes this by ending streams on `a` or on an `a` followed by a digit, then starting a fresh stream at once. The new stream's first block is judged against a character-walking model that starts with no history. Carries that cross a boundary are checked the same way: runs of digits and `a` characters fall on block edges, and a small field width makes carries ripple through all-ones fields of the adder.

// File: rtl/mstar_pkg.sv
package mstar_pkg;
  // Strobes passed from the handshake control to the datapath
  typedef struct packed {
    logic loadBlk;      // a block is accepted on this edge
    logic freshStream;  // accepted block starts a new stream
  } mstarStrobe_t;
endpackage

// File: rtl/mstar_advance.sv
// Moves every marker one character later, feeding bit 0 from the previous block
module mstar_advance #(
  parameter int W = 128
) (
  input  logic [W-1:0] bitsIn,
  input  logic         carryIn,
  output logic [W-1:0] bitsOut,
  output logic         carryOut
);
  assign bitsOut  = {bitsIn[W-2:0], carryIn};
  assign carryOut = bitsIn[W-1];
endmodule

// File: rtl/mstar_star.sv
// Extends markers through runs of class characters with one block-wide add
module mstar_star #(
  parameter int W       = 128,
  parameter int FIELD_W = 64
) (
  input  logic [W-1:0] markIn,
  input  logic [W-1:0] clsIn,
  input  logic         carryIn,
  output logic [W-1:0] markOut,
  output logic         carryOut
);
  localparam int NF = (FIELD_W >= W) ? 1 : W / FIELD_W;
  localparam int FW = W / NF;

  logic [W-1:0] gated;
  logic [W-1:0] sumBits;

  assign gated = markIn & clsIn;

  generate
    if (NF == 1) begin : g_flat
      logic [W:0] full;
      assign full     = {1'b0, gated} + {1'b0, clsIn} + {{W{1'b0}}, carryIn};
      assign sumBits  = full[W-1:0];
      assign carryOut = full[W];
    end else begin : g_split
      logic [NF-1:0] genC;
      logic [NF-1:0] bub;
      logic [W-1:0]  rawSum;
      for (genvar f = 0; f < NF; f++) begin : g_field
        logic [FW:0] part;
        assign part                = {1'b0, gated[f*FW +: FW]} + {1'b0, clsIn[f*FW +: FW]};
        assign rawSum[f*FW +: FW]  = part[FW-1:0];
        assign genC[f]             = part[FW];
        assign bub[f]              = &part[FW-1:0];
      end
      // field-level carry resolution: carries bubble through all-ones fields
      logic [NF:0] seed;
      logic [NF:0] bubX;
      logic [NF:0] incM;
      assign seed = {genC, carryIn};
      assign bubX = {1'b0, bub};
      assign incM = (((seed & bubX) + bubX) ^ bubX) | seed;
      for (genvar f = 0; f < NF; f++) begin : g_fix
        assign sumBits[f*FW +: FW] = rawSum[f*FW +: FW] + {{(FW-1){1'b0}}, incM[f]};
      end
      assign carryOut = incM[NF];
    end
  endgenerate

  assign markOut = (sumBits ^ clsIn) | markIn;
endmodule

// File: rtl/mstar_ctrl.sv
module mstar_ctrl
  import mstar_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         startStream,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output mstarStrobe_t st
);
  assign inReady        = !outValid || outReady;
  assign st.loadBlk     = inValid && inReady;
  assign st.freshStream = startStream;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outValid <= 1'b0;
    else if (st.loadBlk) outValid <= 1'b1;
    else if (outReady)   outValid <= 1'b0;
  end

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadBlk |=> outValid);

  p_stall_keeps_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/mstar_dp.sv
module mstar_dp
  import mstar_pkg::*;
#(
  parameter int W       = 128,
  parameter int FIELD_W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mstarStrobe_t st,
  input  logic [W-1:0] clsA,
  input  logic [W-1:0] clsDigit,
  input  logic [W-1:0] clsEnd,
  output logic [W-1:0] afterA,
  output logic [W-1:0] afterRun,
  output logic [W-1:0] afterEnd
);
  logic carryA, carryRun, carryEnd;
  logic cinA, cinRun, cinEnd;
  logic coutA, coutRun, coutEnd;
  logic [W-1:0] m1, m2, m3;
  logic [W-1:0] termRun;

  assign cinA   = st.freshStream ? 1'b0 : carryA;
  assign cinRun = st.freshStream ? 1'b0 : carryRun;
  assign cinEnd = st.freshStream ? 1'b0 : carryEnd;

  mstar_advance #(.W(W)) u_advA (
    .bitsIn(clsA), .carryIn(cinA), .bitsOut(m1), .carryOut(coutA));

  mstar_star #(.W(W), .FIELD_W(FIELD_W)) u_star (
    .markIn(m1), .clsIn(clsDigit), .carryIn(cinRun), .markOut(m2), .carryOut(coutRun));

  assign termRun = m2 & clsEnd;

  mstar_advance #(.W(W)) u_advEnd (
    .bitsIn(termRun), .carryIn(cinEnd), .bitsOut(m3), .carryOut(coutEnd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carryA   <= 1'b0;
      carryRun <= 1'b0;
      carryEnd <= 1'b0;
      afterA   <= '0;
      afterRun <= '0;
      afterEnd <= '0;
    end else if (st.loadBlk) begin
      carryA   <= coutA;
      carryRun <= coutRun;
      carryEnd <= coutEnd;
      afterA   <= m1;
      afterRun <= m2;
      afterEnd <= m3;
    end
  end

  p_m2_covers_m1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (afterA & ~afterRun) == '0);

  p_m3_from_m2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (afterEnd[W-1:1] & ~afterRun[W-2:0]) == '0);

  p_fresh_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st.loadBlk && st.freshStream) |=> (!afterA[0] && !afterEnd[0]));
endmodule

// File: rtl/mstar_engine.sv
module mstar_engine
  import mstar_pkg::*;
#(
  parameter int BLOCK_W = 128,
  parameter int FIELD_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  output logic               inReady,
  input  logic               startStream,
  input  logic [BLOCK_W-1:0] clsA,
  input  logic [BLOCK_W-1:0] clsDigit,
  input  logic [BLOCK_W-1:0] clsEnd,
  output logic               outValid,
  input  logic               outReady,
  output logic [BLOCK_W-1:0] afterA,
  output logic [BLOCK_W-1:0] afterRun,
  output logic [BLOCK_W-1:0] afterEnd
);
  mstarStrobe_t st;

  mstar_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .startStream(startStream),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .st(st));

  mstar_dp #(.W(BLOCK_W), .FIELD_W(FIELD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .clsA(clsA), .clsDigit(clsDigit),
    .clsEnd(clsEnd), .afterA(afterA), .afterRun(afterRun), .afterEnd(afterEnd));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> ($stable(afterA) && $stable(afterRun) && $stable(afterEnd)));
endmodule

// File: tb/sim_mstar_engine.sv
module sim_mstar_engine;
  localparam int BW   = 16;
  localparam int FW   = 4;
  localparam int MAXB = 10;
  localparam int MAXC = BW * MAXB;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, inValid, inReady, startStream, outValid, outReady;
  logic [BW-1:0] clsA, clsDigit, clsEnd, afterA, afterRun, afterEnd;

  mstar_engine #(.BLOCK_W(BW), .FIELD_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .startStream(startStream), .clsA(clsA), .clsDigit(clsDigit), .clsEnd(clsEnd),
    .outValid(outValid), .outReady(outReady), .afterA(afterA),
    .afterRun(afterRun), .afterEnd(afterEnd));

  byte           txt [MAXC];
  logic          refM1 [MAXC];
  logic          refM2 [MAXC];
  logic          refM3 [MAXC];
  logic [BW-1:0] capM3 [MAXB];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isA(byte c);   return c == 8'd97; endfunction
  function automatic bit isDig(byte c); return c >= 8'd48 && c <= 8'd57; endfunction
  function automatic bit isEnd(byte c); return c == 8'd122 || c == 8'd57; endfunction

  // character-at-a-time model of the pattern
  task automatic buildRef(input int n);
    for (int k = 0; k < n; k++) begin
      refM1[k] = (k > 0) && isA(txt[k-1]);
      refM2[k] = refM1[k] || ((k > 0) && refM2[k-1] && isDig(txt[k-1]));
      refM3[k] = (k > 0) && refM2[k-1] && isEnd(txt[k-1]);
    end
  endtask

  function automatic logic [BW-1:0] clsOf(input int b, input int kind);
    logic [BW-1:0] v;
    for (int k = 0; k < BW; k++) begin
      byte c;
      c = txt[b*BW + k];
      v[k] = (kind == 0) ? isA(c) : (kind == 1) ? isDig(c) : isEnd(c);
    end
    return v;
  endfunction

  function automatic logic [BW-1:0] refWord(input int b, input int which);
    logic [BW-1:0] v;
    for (int k = 0; k < BW; k++)
      v[k] = (which == 1) ? refM1[b*BW+k] : (which == 2) ? refM2[b*BW+k] : refM3[b*BW+k];
    return v;
  endfunction

  task automatic runStream(input int nb, input int stallMax);
    buildRef(nb * BW);
    for (int b = 0; b < nb; b++) begin
      int stall;
      @(negedge clk);
      clsA = clsOf(b, 0); clsDigit = clsOf(b, 1); clsEnd = clsOf(b, 2);
      startStream = (b == 0); inValid = 1'b1; outReady = 1'b0;
      @(negedge clk);
      inValid = 1'b0;
      // garbage while no block is offered must have no effect (R9, R8)
      startStream = 1'($urandom % 2);
      clsA = BW'($urandom); clsDigit = BW'($urandom); clsEnd = BW'($urandom);
      chk("R9 outValid after accept", BW'(outValid), BW'(1));
      stall = int'($urandom % (stallMax + 1));
      for (int s = 0; s < stall; s++) begin
        chk("R9 inReady low while stalled", BW'(inReady), BW'(0));
        @(negedge clk);
      end
      chk((b == 0) ? "R2 R8 afterA" : "R2 R7 afterA", afterA, refWord(b, 1));
      chk((b == 0) ? "R3 R8 afterRun" : "R3 R6 afterRun", afterRun, refWord(b, 2));
      chk((b == 0) ? "R5 R8 afterEnd" : "R5 R7 afterEnd", afterEnd, refWord(b, 3));
      capM3[b] = afterEnd;
      outReady = 1'b1;
      @(negedge clk);
      chk("R9 drained", BW'(outValid), BW'(0));
      chk("R9 inReady when idle", BW'(inReady), BW'(1));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string s;
    rst_n = 1'b0; inValid = 1'b0; startStream = 1'b0; outReady = 1'b0;
    clsA = '0; clsDigit = '0; clsEnd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", BW'(outValid), BW'(0));
    chk("R1 inReady after reset", BW'(inReady), BW'(1));

    // ambiguous run: every end reachable (R4)
    s = "a12949z";
    for (int i = 0; i < BW; i++) txt[i] = (i < s.len()) ? s[i] : 8'd45;
    runStream(1, 2);
    chk("R4 all ends marked", capM3[0], 16'h00D0);

    // mixed text over three blocks, runs crossing edges
    s = "a453z--b3z--az--a12949z--ca22z7--";
    for (int i = 0; i < 3*BW; i++) txt[i] = (i < s.len()) ? s[i] : 8'd45;
    runStream(3, 1);

    // random streams; tails often leave live carries for the next stream (R8)
    for (int t = 0; t < 120; t++) begin
      int nb, n;
      nb = 1 + int'($urandom % MAXB);
      n  = nb * BW;
      for (int i = 0; i < n; i++) begin
        int r;
        r = int'($urandom % 10);
        if (r < 2)      txt[i] = 8'd97;
        else if (r < 7) txt[i] = byte'(8'd48 + 8'($urandom % 10));
        else if (r < 8) txt[i] = 8'd122;
        else            txt[i] = 8'd45;
      end
      case ($urandom % 3)
        0: txt[n-1] = 8'd97;
        1: begin txt[n-2] = 8'd97; txt[n-1] = 8'd53; end
        default: ;
      endcase
      runStream(nb, 3);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule